// File: doc/BRIEF.md
# Bus transfer timeout monitor

This block keeps a watch on every data-transfer cycle on a shared backplane, whichever master started it. A single counter times each cycle from the first clock edge at which the cycle-active strobe is seen high. If neither a slave acknowledge nor an existing bus-error indication arrives within a programmed number of clocks, the monitor drives bus error. That ends the hung cycle, so a missing or broken slave cannot stall the system. Bus error says only that the cycle failed. No cause code is produced.

The limit sits in a writable register, and a limit of zero turns the monitor off. Cycles flagged as address-only are never timed, because they end without any acknowledge. A sticky status flag records that a timeout happened, and a write-one-to-clear input resets it.

The control path is a four-state machine:

| State | Meaning |
|---|---|
| IDLE | No cycle is open. |
| TIMING | A cycle is being counted. |
| DONE | The cycle is finished or exempt, and the monitor waits for the strobe to drop. |
| FAULT | Bus error is being driven. |

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→TIMING | Start of a timed cycle. |
| IDLE→DONE | Address-only cycle, zero limit, or acknowledge / bus error already present. |
| TIMING→DONE | Acknowledge, external bus error, or zero limit. |
| TIMING→FAULT | Expiry. |
| TIMING/DONE/FAULT→IDLE | Strobe released. |

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, `berr_o` and `timeout_flag_o` are 0 and the limit register holds RESET_LIMIT (default 0, so the monitor starts disabled).
- R2: With limit L (L not 0) and a cycle that is not address-only and gets no acknowledge or bus error, `berr_o` is first seen high after the rising edge at which the strobe has been sampled high for the (L+1)-th consecutive time.
- R3: An acknowledge or external bus error sampled while the strobe is high and `berr_o` is low ends timing for that cycle, and no timeout follows. This holds even at the edge where expiry would occur, because acknowledge wins.
- R4: The cycle type (`addr_only_i` = 1 means address-only) is sampled only at the first edge of a cycle. Address-only cycles are never timed out, and later changes of `addr_only_i` within a cycle have no effect.
- R5: While the limit is 0, no cycle is timed out.
- R6: `berr_o` stays high while the strobe is high and drops at the first edge where the strobe is sampled low. A new cycle after a single low edge is timed afresh for the full limit.
- R7: `timeout_flag_o` goes high at the same edge as `berr_o` rises and stays high until cleared.
- R8: `flag_clr_i` high at an edge clears the flag. If a timeout happens at the same edge, the flag stays set.
- R9: `lim_we_i` high at an edge loads `lim_wdata_i` into the limit register, and the value governs subsequent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_i | input | 1 | Cycle-active strobe |
| addr_only_i | input | 1 | Cycle type: 1 for an address-only cycle |
| ack_i | input | 1 | Slave acknowledge |
| berr_in_i | input | 1 | Bus error driven by another agent |
| lim_we_i | input | 1 | Limit register write enable |
| lim_wdata_i | input | CNT_W | Limit value to write |
| flag_clr_i | input | 1 | Write-one-to-clear for the timeout flag |
| berr_o | output | 1 | Bus-error drive |
| timeout_flag_o | output | 1 | Sticky timeout status |

## Verification
Two functions can fall on the same edge: the slave's acknowledge and the expiry of the count. The bench sweeps the acknowledge, and separately the external bus error, over every edge from the first sample to one past expiry, for each small limit. The expected outcome is computed arithmetically: a fault is expected only when the terminating edge comes later than edge L+1. A second collision, a flag clear on the expiry edge, is provoked and must leave the flag set.

// File: rtl/btm_pkg.sv
package btm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_DONE   = 2'd2,
        ST_FAULT  = 2'd3
    } btm_state_e;
endpackage

// File: rtl/btm_limit_reg.sv
module btm_limit_reg #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RESET_LIMIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] limit_o,
    output logic             limit_zero_o
);
    logic [CNT_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lim_q <= RESET_LIMIT;
        else if (we_i)
            lim_q <= wdata_i;
    end

    assign limit_o      = lim_q;
    assign limit_zero_o = (lim_q == '0);
endmodule

// File: rtl/btm_cycle_timer.sv
module btm_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             start_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= ONE;
        else if (inc_i)
            cnt_q <= cnt_q + ONE;
    end

    // A lowered limit mid-cycle still expires: compare with >=
    assign expired_o = (limit_i != '0) && (cnt_q >= limit_i);
endmodule

// File: rtl/btm_ctrl_fsm.sv
module btm_ctrl_fsm
    import btm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_i,
    input  logic addr_only_i,
    input  logic ack_i,
    input  logic berr_in_i,
    input  logic limit_zero_i,
    input  logic expired_i,
    output logic berr_drive_o,
    output logic timeout_evt_o,
    output logic cnt_start_o,
    output logic cnt_inc_o,
    output logic cnt_clr_o
);
    btm_state_e state_q;
    btm_state_e state_d;
    logic       finished;

    assign finished = ack_i | berr_in_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_i) begin
                    if (addr_only_i || limit_zero_i || finished)
                        state_d = ST_DONE;
                    else
                        state_d = ST_TIMING;
                end
            end
            ST_TIMING: begin
                if (!cyc_i)
                    state_d = ST_IDLE;
                else if (finished || limit_zero_i)
                    state_d = ST_DONE;
                else if (expired_i)
                    state_d = ST_FAULT;
            end
            ST_DONE: begin
                if (!cyc_i)
                    state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (!cyc_i)
                    state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        berr_drive_o  = (state_q == ST_FAULT);
        timeout_evt_o = (state_q == ST_TIMING) && (state_d == ST_FAULT);
        cnt_start_o   = (state_q == ST_IDLE) && (state_d == ST_TIMING);
        cnt_inc_o     = (state_q == ST_TIMING) && (state_d == ST_TIMING);
        cnt_clr_o     = !cyc_i;
    end
endmodule

// File: rtl/btm_sticky_flag.sv
module btm_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RESET_LIMIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_i,
    input  logic             addr_only_i,
    input  logic             ack_i,
    input  logic             berr_in_i,
    input  logic             lim_we_i,
    input  logic [CNT_W-1:0] lim_wdata_i,
    input  logic             flag_clr_i,
    output logic             berr_o,
    output logic             timeout_flag_o
);
    logic [CNT_W-1:0] lim_q;
    logic             lim_zero;
    logic             expired;
    logic             timeout_evt;
    logic             cnt_start;
    logic             cnt_inc;
    logic             cnt_clr;

    btm_limit_reg #(.CNT_W(CNT_W), .RESET_LIMIT(RESET_LIMIT)) u_limit (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (lim_we_i),
        .wdata_i      (lim_wdata_i),
        .limit_o      (lim_q),
        .limit_zero_o (lim_zero)
    );

    btm_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cnt_clr),
        .start_i   (cnt_start),
        .inc_i     (cnt_inc),
        .limit_i   (lim_q),
        .expired_o (expired)
    );

    btm_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_i         (cyc_i),
        .addr_only_i   (addr_only_i),
        .ack_i         (ack_i),
        .berr_in_i     (berr_in_i),
        .limit_zero_i  (lim_zero),
        .expired_i     (expired),
        .berr_drive_o  (berr_o),
        .timeout_evt_o (timeout_evt),
        .cnt_start_o   (cnt_start),
        .cnt_inc_o     (cnt_inc),
        .cnt_clr_o     (cnt_clr)
    );

    btm_sticky_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (timeout_evt),
        .clr_i  (flag_clr_i),
        .flag_o (timeout_flag_o)
    );
endmodule

// File: rtl/btm_checker.sv
module btm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_i,
    input logic             addr_only_i,
    input logic             ack_i,
    input logic             berr_in_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] lim_q,
    input logic             berr_o,
    input logic             timeout_flag_o
);
    // R3: a termination seen before any fault prevents a timeout
    p_end_blocks_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_i && (ack_i || berr_in_i) && !berr_o) |=> !berr_o);

    // R4: address-only cycle is not faulted at its first edge
    p_addr_only_exempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cyc_i) && addr_only_i) |=> !berr_o);

    // R5: zero limit never starts a fault
    p_zero_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((lim_q == '0) && !berr_o) |=> !berr_o);

    // R6: bus error is held while the strobe stays high
    p_hold_berr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_o && cyc_i) |=> berr_o);

    // R6: bus error drops once the strobe is released
    p_release_berr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_i |=> !berr_o);

    // R7: flag rises together with bus error
    p_flag_with_berr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr_o) |-> timeout_flag_o);

    // R7: flag is sticky without a clear
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag_o && !flag_clr_i) |=> timeout_flag_o);
endmodule

bind bus_timeout_monitor btm_checker #(.CNT_W(CNT_W)) u_btm_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cyc_i          (cyc_i),
    .addr_only_i    (addr_only_i),
    .ack_i          (ack_i),
    .berr_in_i      (berr_in_i),
    .flag_clr_i     (flag_clr_i),
    .lim_q          (lim_q),
    .berr_o         (berr_o),
    .timeout_flag_o (timeout_flag_o)
);

// File: tb/bus_timeout_monitor_bench.sv
module bus_timeout_monitor_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cyc = 1'b0;
    logic         addr_only = 1'b0;
    logic         ack = 1'b0;
    logic         berr_in = 1'b0;
    logic         lim_we = 1'b0;
    logic [W-1:0] lim_wdata = '0;
    logic         flag_clr = 1'b0;
    logic         berr_o;
    logic         timeout_flag_o;

    int checks = 0;
    int errors = 0;
    int cur_lim = 0;
    bit exp_flag = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_timeout_monitor #(.CNT_W(W)) u_bus_timeout_monitor (
        .clk            (clk),
        .rst_n          (rst_n),
        .cyc_i          (cyc),
        .addr_only_i    (addr_only),
        .ack_i          (ack),
        .berr_in_i      (berr_in),
        .lim_we_i       (lim_we),
        .lim_wdata_i    (lim_wdata),
        .flag_clr_i     (flag_clr),
        .berr_o         (berr_o),
        .timeout_flag_o (timeout_flag_o)
    );

    task automatic chk(string req, string what, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b (limit %0d)", req, what, act, expv, cur_lim);
        end
    endtask

    task automatic set_limit(int v);
        lim_we    = 1'b1;
        lim_wdata = W'(v);
        @(posedge clk); @(negedge clk);
        lim_we  = 1'b0;
        cur_lim = v;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        flag_clr = 1'b0;
        exp_flag = 1'b0;
        chk("R8", "flag after clear", timeout_flag_o, 1'b0);
    endtask

    // One cycle of len edges; *_at give the edge index (1 = first sample), 0 = never
    task automatic run_cyc(string req, int ack_at, int xb_at, int clr_at, bit ao, int len);
        bit faulted = 1'b0;
        bit ended   = 1'b0;
        cyc       = 1'b1;
        addr_only = ao;
        for (int e = 1; e <= len; e++) begin
            bit set_now = 1'b0;
            ack      = (e == ack_at);
            berr_in  = (e == xb_at);
            flag_clr = (e == clr_at);
            if (e == 2) addr_only = ~ao;
            @(posedge clk); @(negedge clk);
            if (!faulted && !ended) begin
                if (e == ack_at || e == xb_at || ao || cur_lim == 0)
                    ended = 1'b1;
                else if (e == cur_lim + 1) begin
                    faulted = 1'b1;
                    set_now = 1'b1;
                end
            end
            if (set_now) exp_flag = 1'b1;
            else if (e == clr_at) exp_flag = 1'b0;
            chk(req, "berr_o", berr_o, faulted);
            chk(req, "timeout_flag_o", timeout_flag_o, exp_flag);
        end
        ack = 1'b0; berr_in = 1'b0; flag_clr = 1'b0; cyc = 1'b0; addr_only = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R6", "berr_o after release", berr_o, 1'b0);
        chk("R7", "flag after release", timeout_flag_o, exp_flag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "berr_o reset", berr_o, 1'b0);
        chk("R1", "flag reset", timeout_flag_o, 1'b0);
        // R1: reset limit is zero, so a long cycle is never timed out
        run_cyc("R1", 0, 0, 0, 1'b0, 6);

        // R2 + R6: plain expiry sweep, back-to-back cycles
        for (int l = 1; l <= 6; l++) begin
            set_limit(l);
            run_cyc("R2", 0, 0, 0, 1'b0, l + 3);
            run_cyc("R6", 0, 0, 0, 1'b0, l + 2);
            clear_flag();
        end

        // R3: acknowledge and external bus error at every edge around expiry
        for (int l = 1; l <= 4; l++) begin
            set_limit(l);
            for (int k = 1; k <= l + 2; k++) begin
                run_cyc("R3", k, 0, 0, 1'b0, l + 3);
                run_cyc("R3", 0, k, 0, 1'b0, l + 3);
            end
            clear_flag();
        end

        // R4: address-only cycles are exempt, later type change ignored
        for (int l = 1; l <= 3; l++) begin
            set_limit(l);
            run_cyc("R4", 0, 0, 0, 1'b1, l + 4);
        end

        // R5: zero limit disables
        set_limit(0);
        run_cyc("R5", 0, 0, 0, 1'b0, 12);

        // R7: flag survives a following clean cycle
        set_limit(2);
        run_cyc("R7", 0, 0, 0, 1'b0, 4);
        run_cyc("R7", 1, 0, 0, 1'b0, 4);
        chk("R7", "flag sticky", timeout_flag_o, 1'b1);

        // R8: clear on the expiry edge loses; clear after expiry wins
        clear_flag();
        set_limit(3);
        run_cyc("R8", 0, 0, 4, 1'b0, 6);
        run_cyc("R8", 0, 0, 6, 1'b0, 7);

        // R9: a newly written larger limit governs the next cycle
        set_limit(9);
        run_cyc("R9", 0, 0, 0, 1'b0, 12);
        set_limit(1);
        run_cyc("R9", 0, 0, 0, 1'b0, 3);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule